// File: doc/BRIEF.md
# Fractional 100 Hz Tick Generator

This block turns a 32.768 kHz clock-enable stream into a 100 Hz tick using only integer counters. A divide-by-8 prescaler first produces a 4096 Hz enable. A dual-modulus counter then counts those enables: it divides by 41 for twenty-four output periods and by 40 for the twenty-fifth. Twenty-five such periods hold exactly 1024 enables, which is 250 ms. The long-run rate is therefore exactly 100 Hz, and the phase error cancels at the end of every 25-tick frame.

A 1024 Hz square wave comes from the same 4096 Hz enable, divided by 4. Every output is a register in the system clock domain. The reference enable is a one-cycle strobe in that domain, and a cycle where it is low advances nothing.

Top module: `frac_tick_gen`

## Requirements
- R1: After a cycle with `rst` high, all three outputs are 0. The first `tick_100_o` pulse comes in the cycle after the `ref_en` cycle that carries the 328th reference pulse counted from reset, which is the 41st 4096 Hz enable.
- R2: `tick_4096_o` is a one-cycle pulse in the cycle after every 8th `ref_en` pulse.
- R3: Cycles with `ref_en` low do not advance any counter, and no output changes in the cycle after them.
- R4: Counted in `tick_4096_o` pulses since the previous tick (or since reset), tick number k has a period of 40 when k is a multiple of 25 and 41 otherwise.
- R5: When tick number 25·j occurs, exactly 1024·j `tick_4096_o` pulses have been issued since reset.
- R6: `tick_100_o` is a one-cycle pulse, and it is only high in a cycle where `tick_4096_o` is also high.
- R7: `sq_1024_o` starts at 0 and is 1 after the 2nd and 3rd `tick_4096_o` pulses of each group of four. It is 0 after the 4th and the 1st. It changes only in cycles where `tick_4096_o` is high.
- R8: Asserting `rst` in the middle of a frame restarts the sequence, so the R1 timing applies again from the release of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | One-cycle strobe at the 32.768 kHz reference rate |
| tick_4096_o | output | 1 | One-cycle strobe at 4096 Hz |
| tick_100_o | output | 1 | One-cycle strobe averaging exactly 100 Hz |
| sq_1024_o | output | 1 | 1024 Hz square wave, 50% duty in enable counts |

## Verification
The reference strobe is driven in three patterns:
- **Back-to-back:** a strobe on every cycle, the densest case. It checks that no enable is lost or double-counted at the prescaler and modulus wraps.
- **Every third cycle:** a regular gap pattern. It separates counting strobes from counting clock cycles.
- **Irregular bursts:** a pseudo-random pattern with a long idle stretch. It shows that idle cycles leave all state untouched.

Measured tick periods distinguish a correct 41/40 schedule from one that places the short period wrongly or never uses it. A reset asserted mid-frame confirms that the sequence position restarts.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

    localparam int REF_PRE_DIV = 8;
    localparam int SQ_DIV      = 4;
    localparam int MOD_LONG    = 41;
    localparam int LONG_RUN    = 24;

    typedef enum logic {
        MOD_SEL_LONG  = 1'b0,
        MOD_SEL_SHORT = 1'b1
    } mod_sel_e;

    function automatic mod_sel_e pick_modulus(input int unsigned idx,
                                              input int unsigned long_run);
        return (idx >= long_run) ? MOD_SEL_SHORT : MOD_SEL_LONG;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/frac_prescaler.sv
module frac_prescaler
    import frac_div_pkg::*;
#(
    parameter int DIV = REF_PRE_DIV
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_en,
    output logic en_comb,
    output logic en_q
);
    localparam int W = cnt_width(DIV);

    logic [W-1:0] cnt_q;
    logic         at_last;

    assign at_last = (cnt_q == W'(DIV - 1));
    assign en_comb = ref_en & at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
        end else begin
            en_q <= en_comb;
            if (ref_en) begin
                cnt_q <= at_last ? '0 : cnt_q + W'(1);
            end
        end
    end

    // R3
    ref_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !ref_en |=> !en_q);

    // R2
    en_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        en_q |=> !en_q);

endmodule

// File: rtl/frac_dual_mod_seq.sv
module frac_dual_mod_seq
    import frac_div_pkg::*;
#(
    parameter int MODL = MOD_LONG,
    parameter int RUN  = LONG_RUN
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick_q
);
    localparam int MW = cnt_width(MODL);
    localparam int SW = cnt_width(RUN + 1);

    typedef struct packed {
        logic [SW-1:0] seq_idx;
        logic [MW-1:0] mod_cnt;
    } seq_state_t;

    seq_state_t    state_q, state_d;
    mod_sel_e      sel;
    logic [MW-1:0] last_val;
    logic          wrap;

    assign sel      = pick_modulus(int'(state_q.seq_idx), RUN);
    assign last_val = (sel == MOD_SEL_LONG) ? MW'(MODL - 1) : MW'(MODL - 2);
    assign wrap     = en && (state_q.mod_cnt == last_val);

    always_comb begin
        state_d = state_q;
        if (en) begin
            if (wrap) begin
                state_d.mod_cnt = '0;
                state_d.seq_idx = (state_q.seq_idx == SW'(RUN)) ? '0
                                : state_q.seq_idx + SW'(1);
            end else begin
                state_d.mod_cnt = state_q.mod_cnt + MW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            tick_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            tick_q  <= wrap;
        end
    end

    // R4
    seq_idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        state_q.seq_idx <= SW'(RUN));

    // R4
    mod_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        state_q.mod_cnt <= MW'(MODL - 1));

    // R6
    tick_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tick_q |=> !tick_q);

endmodule

// File: rtl/frac_sq_tap.sv
module frac_sq_tap
    import frac_div_pkg::*;
#(
    parameter int DIV = SQ_DIV
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic sq_q
);
    localparam int W    = cnt_width(DIV);
    localparam int HALF = DIV / 2;

    logic [W-1:0] cnt_q, cnt_nx;

    assign cnt_nx = (cnt_q == W'(DIV - 1)) ? '0 : cnt_q + W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sq_q  <= 1'b0;
        end else if (en) begin
            cnt_q <= cnt_nx;
            sq_q  <= (cnt_nx >= W'(HALF));
        end
    end

endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen
    import frac_div_pkg::*;
#(
    parameter int PRE_DIV = REF_PRE_DIV,
    parameter int SQ_DIVN = SQ_DIV,
    parameter int MODL    = MOD_LONG,
    parameter int RUN     = LONG_RUN
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_en,
    output logic tick_4096_o,
    output logic tick_100_o,
    output logic sq_1024_o
);
    logic en_4096;

    frac_prescaler #(.DIV(PRE_DIV)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .ref_en  (ref_en),
        .en_comb (en_4096),
        .en_q    (tick_4096_o)
    );

    frac_dual_mod_seq #(.MODL(MODL), .RUN(RUN)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .en     (en_4096),
        .tick_q (tick_100_o)
    );

    frac_sq_tap #(.DIV(SQ_DIVN)) u_sq (
        .clk  (clk),
        .rst  (rst),
        .en   (en_4096),
        .sq_q (sq_1024_o)
    );

    // R6
    tick_align_chk: assert property (@(posedge clk) disable iff (rst)
        tick_100_o |-> tick_4096_o);

    // R7
    sq_edge_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(sq_1024_o) || $fell(sq_1024_o)) |-> tick_4096_o);

endmodule

// File: tb/frac_tick_gen_tb.sv
module frac_tick_gen_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_en = 1'b0;
    logic tick_4096_o, tick_100_o, sq_1024_o;

    always #2 clk = ~clk;

    frac_tick_gen u_dut (
        .clk         (clk),
        .rst         (rst),
        .ref_en      (ref_en),
        .tick_4096_o (tick_4096_o),
        .tick_100_o  (tick_100_o),
        .sq_1024_o   (sq_1024_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference model
    int  n_ref, m_en, k_tick, next_bound;
    bit  exp_t4, exp_t100, exp_sq;

    always @(posedge clk) begin
        if (rst) begin
            n_ref = 0; m_en = 0; k_tick = 0; next_bound = 41;
            exp_t4 = 0; exp_t100 = 0; exp_sq = 0;
        end else begin
            exp_t4 = 0;
            exp_t100 = 0;
            if (ref_en) begin
                n_ref = n_ref + 1;
                if (n_ref % 8 == 0) begin
                    exp_t4 = 1;
                    m_en = m_en + 1;
                    exp_sq = ((m_en % 4) >= 2);
                    if (m_en == next_bound) begin
                        exp_t100 = 1;
                        k_tick = k_tick + 1;
                        next_bound = next_bound + ((((k_tick + 1) % 25) == 0) ? 40 : 41);
                    end
                end
            end
        end
    end

    // measurement state taken from the outputs only
    int  seen_en, since_tick, seen_ticks;
    bit  after_mid_rst;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic step(input bit r, input bit e);
        @(negedge clk);
        chk(tick_4096_o == exp_t4, "R2 tick_4096", int'(tick_4096_o), int'(exp_t4));
        chk(tick_100_o == exp_t100, "R6 tick_100", int'(tick_100_o), int'(exp_t100));
        chk(sq_1024_o == exp_sq, "R7 sq_1024", int'(sq_1024_o), int'(exp_sq));
        if (tick_100_o) chk(tick_4096_o, "R6 align", int'(tick_4096_o), 1);
        if (rst) begin
            seen_en = 0; since_tick = 0; seen_ticks = 0;
        end else if (tick_4096_o) begin
            seen_en++;
            since_tick++;
            if (tick_100_o) begin
                seen_ticks++;
                if (seen_ticks == 1)
                    chk(since_tick == 41, after_mid_rst ? "R8 first period" : "R1 first period",
                        since_tick, 41);
                chk(since_tick == (((seen_ticks % 25) == 0) ? 40 : 41), "R4 period",
                    since_tick, ((seen_ticks % 25) == 0) ? 40 : 41);
                if ((seen_ticks % 25) == 0)
                    chk(seen_en == 1024 * (seen_ticks / 25), "R5 frame phase",
                        seen_en, 1024 * (seen_ticks / 25));
                since_tick = 0;
            end
        end
        rst = r;
        ref_en = e;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=%0d exp=0", cyc);
            finish_run();
        end
    end

    initial begin
        logic [15:0] lfsr;
        bit sq_hold;
        lfsr = 16'hACE1;
        after_mid_rst = 0;
        seen_en = 0; since_tick = 0; seen_ticks = 0;
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
        // R1: reset state
        @(negedge clk);
        chk(!tick_4096_o && !tick_100_o && !sq_1024_o, "R1 reset state",
            int'({tick_4096_o, tick_100_o, sq_1024_o}), 0);
        rst = 1'b0;
        // back-to-back strobes: two frames
        for (int i = 0; i < 16600; i++) step(1'b0, 1'b1);
        // strobe every third cycle
        for (int i = 0; i < 27000; i++) step(1'b0, (i % 3) == 0);
        // R3: long idle stretch, nothing may move
        sq_hold = sq_1024_o;
        for (int i = 0; i < 60; i++) begin
            step(1'b0, 1'b0);
            if (i > 0) begin
                chk(!tick_4096_o && !tick_100_o, "R3 idle ticks",
                    int'({tick_4096_o, tick_100_o}), 0);
                chk(sq_1024_o == sq_hold, "R3 idle sq", int'(sq_1024_o), int'(sq_hold));
            end
        end
        // irregular bursts
        for (int i = 0; i < 12000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(1'b0, lfsr[0] | lfsr[1]);
        end
        // R8: reset in the middle of a frame
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
        after_mid_rst = 1;
        for (int i = 0; i < 9000; i++) step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        chk(seen_ticks >= 25, "R8 ticks after reset", seen_ticks, 25);
        finish_run();
    end

endmodule